// File: doc/BRIEF.md
# Power-of-Two Offset Multiplier

This block multiplies two unsigned operands of parameterized width (16 bits by default) and returns the full double-width product. It does not reduce a field of partial products. Each operand is written as the nearest power of two plus or minus a residual: `v = 2^c ± S`. The product is then built as `2^cb·A ± S_b·2^ca ± S_a·S_b`. The two power-of-two terms are single shifts of variable amount, so each costs one shifter pass. Only the residual product `S_a·S_b` needs a true multiplier. That product is small, because no residual is larger than a quarter of the operand range, and it is formed by column-wise cross-product accumulation.

An exponent comparator orders the operands. The one with the larger selected exponent takes the role of `A`, which gives `ca ≥ cb`. The caller presents operands with `in_valid` and receives the registered product one clock later with `out_valid`. The product register keeps its value while no new operands arrive.

Top module: `bom_mult`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `product` equals `opnd_x × opnd_y` as a full 2·WIDTH-bit unsigned value after that edge. Examples: 10 × 9 = 90, and 0xFFFF × 0xFFFF = 0xFFFE0001.
- R2: `out_valid` is high in exactly the cycle after an edge at which `in_valid` was high, and low otherwise. While `rst_n` is low, `out_valid` and `product` are 0.
- R3: An edge with `in_valid` low leaves `product` unchanged, whatever values are on the operand inputs.
- R4: If either operand is 0, the product is 0.
- R5: Each operand with leading one at bit p uses base 2^p when it is at most 3·2^(p−1), and base 2^(p+1) otherwise. An operand of 1 uses base 1 with residual 0. No residual magnitude exceeds 2^(WIDTH−2). Midpoint operands, and operands one above and one below a midpoint, give exact products.
- R6: The operand with the larger selected exponent is used as the shifted term. Swapping `opnd_x` and `opnd_y` gives the same product.
- R7: Powers of two, all-ones operands and equal operands give exact products.
- R8: A new operand pair may be presented in every cycle, and each pair's product appears in order in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| opnd_x | input | WIDTH | First unsigned operand |
| opnd_y | input | WIDTH | Second unsigned operand |
| out_valid | output | 1 | `product` carries a new result |
| product | output | 2·WIDTH | Registered unsigned product |

## Verification
The hardest case to reach from the ports is an operand pair where both residuals are subtracted, or where the signs differ and the cross term is shifted by the full exponent. In these cases the signed accumulator swings furthest and a sign slip would show. Random operands rarely land exactly on a midpoint or one step from it. The stimulus therefore walks every bit position p with the values 3·2^(p−1) − 1, 3·2^(p−1) and 3·2^(p−1) + 1, pairs them against all-ones and powers of two, and presents each pair in both orders so that the exponent comparator swaps on one of the two.

// File: rtl/bom_pkg.sv
package bom_pkg;
  // How a residual joins its base: v = 2^c + S or v = 2^c - S
  typedef enum logic {
    RES_ADD = 1'b0,
    RES_SUB = 1'b1
  } res_sign_e;
endpackage

// File: rtl/bom_base_select.sv
module bom_base_select
  import bom_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int RW = WIDTH - 1,
  localparam int EW = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] value,
  output logic             is_zero,
  output logic [EW-1:0]    expo,
  output logic [RW-1:0]    resid,
  output res_sign_e        sign
);

  // position of the leading one
  function automatic int lead_one(input logic [WIDTH-1:0] v);
    int p;
    p = 0;
    for (int i = 0; i < WIDTH; i++) begin
      if (v[i]) p = i;
    end
    return p;
  endfunction

  int         lead;
  logic [WIDTH:0] v_ext, pow_lo, half, below, above;

  always_comb begin
    lead   = lead_one(value);
    v_ext  = {1'b0, value};
    pow_lo = (WIDTH+1)'(1) << lead;
    half   = pow_lo >> 1;
    below  = v_ext - pow_lo;
    above  = (pow_lo << 1) - v_ext;
    is_zero = (value == '0);
    if (is_zero) begin
      expo  = '0;
      resid = '0;
      sign  = RES_ADD;
    end else if (lead != 0 && below > half) begin
      expo  = EW'(lead + 1);
      resid = RW'(above);
      sign  = RES_SUB;
    end else begin
      expo  = EW'(lead);
      resid = RW'(below);
      sign  = RES_ADD;
    end
  end

endmodule

// File: rtl/bom_residual_mult.sv
module bom_residual_mult #(
  parameter int RW = 15,
  localparam int PW = 2 * RW,
  localparam int NC = 2 * RW - 1,
  localparam int CW = $clog2(RW + 1)
) (
  input  logic [RW-1:0] res_a,
  input  logic [RW-1:0] res_b,
  output logic [PW-1:0] res_prod
);

  // one column of vertical-and-crosswise products: bits i, j with i + j = k
  function automatic logic [CW-1:0] column(input logic [RW-1:0] a,
                                            input logic [RW-1:0] b,
                                            input int k);
    logic [CW-1:0] s;
    int j;
    s = '0;
    for (int i = 0; i < RW; i++) begin
      j = k - i;
      if (j >= 0 && j < RW) s = s + CW'(a[i] & b[j]);
    end
    return s;
  endfunction

  logic [CW-1:0] col_sum [NC];

  for (genvar k = 0; k < NC; k++) begin : g_col
    assign col_sum[k] = column(res_a, res_b, k);
  end

  always_comb begin
    res_prod = '0;
    for (int k = 0; k < NC; k++) begin
      res_prod = res_prod + (PW'(col_sum[k]) << k);
    end
  end

endmodule

// File: rtl/bom_mult.sv
module bom_mult
  import bom_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int RW = WIDTH - 1,
  localparam int EW = $clog2(WIDTH + 1),
  localparam int PW = 2 * WIDTH,
  localparam int AW = 2 * WIDTH + 2,
  localparam int HW = AW - PW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] opnd_x,
  input  logic [WIDTH-1:0] opnd_y,
  output logic             out_valid,
  output logic [PW-1:0]    product
);

  // 2^eb*A +/- rb*2^ea +/- ra*rb in a signed accumulator
  function automatic logic signed [AW-1:0] assemble(
      input logic [WIDTH-1:0] a,
      input logic [EW-1:0]    ea,
      input logic [EW-1:0]    eb,
      input logic [RW-1:0]    rb,
      input logic             neg_cross,
      input logic             neg_small,
      input logic [2*RW-1:0]  rr);
    logic signed [AW-1:0] base_t, cross_t, small_t;
    base_t  = $signed(AW'(a) << eb);
    cross_t = $signed(AW'(rb) << ea);
    small_t = $signed(AW'(rr));
    if (neg_cross) cross_t = -cross_t;
    if (neg_small) small_t = -small_t;
    return base_t + cross_t + small_t;
  endfunction

  logic [WIDTH-1:0] opnd [2];
  logic             zf   [2];
  logic [EW-1:0]    ex   [2];
  logic [RW-1:0]    rs   [2];
  res_sign_e        sg   [2];

  assign opnd[0] = opnd_x;
  assign opnd[1] = opnd_y;

  for (genvar g = 0; g < 2; g++) begin : g_sel
    bom_base_select #(.WIDTH(WIDTH)) u_sel (
      .value  (opnd[g]),
      .is_zero(zf[g]),
      .expo   (ex[g]),
      .resid  (rs[g]),
      .sign   (sg[g])
    );
  end

  // exponent comparator: the larger exponent becomes operand A
  logic             swap_ev, zero_ev;
  logic [WIDTH-1:0] val_a;
  logic [EW-1:0]    exp_a, exp_b;
  logic [RW-1:0]    res_a, res_b;
  res_sign_e        sgn_a, sgn_b;

  assign swap_ev = (ex[1] > ex[0]);
  assign zero_ev = zf[0] | zf[1];
  assign val_a   = swap_ev ? opnd[1] : opnd[0];
  assign exp_a   = swap_ev ? ex[1]   : ex[0];
  assign exp_b   = swap_ev ? ex[0]   : ex[1];
  assign res_a   = swap_ev ? rs[1]   : rs[0];
  assign res_b   = swap_ev ? rs[0]   : rs[1];
  assign sgn_a   = swap_ev ? sg[1]   : sg[0];
  assign sgn_b   = swap_ev ? sg[0]   : sg[1];

  logic [2*RW-1:0] res_prod;

  bom_residual_mult #(.RW(RW)) u_rmul (
    .res_a   (res_a),
    .res_b   (res_b),
    .res_prod(res_prod)
  );

  logic signed [AW-1:0] acc_sum;
  logic [HW-1:0]        sum_top;

  assign acc_sum = assemble(val_a, exp_a, exp_b, res_b,
                            sgn_b == RES_SUB,
                            (sgn_a == RES_SUB) ^ (sgn_b == RES_SUB),
                            res_prod);
  assign sum_top = acc_sum[AW-1:PW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) product <= zero_ev ? '0 : acc_sum[PW-1:0];
    end
  end

endmodule

// File: rtl/bom_mult_chk.sv
module bom_mult_chk #(
  parameter int WIDTH = 16,
  localparam int RW = WIDTH - 1,
  localparam int EW = $clog2(WIDTH + 1),
  localparam int PW = 2 * WIDTH,
  localparam int HW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [WIDTH-1:0] opnd_x,
  input logic [WIDTH-1:0] opnd_y,
  input logic             out_valid,
  input logic [PW-1:0]    product,
  input logic             zero_ev,
  input logic [EW-1:0]    exp_a,
  input logic [EW-1:0]    exp_b,
  input logic [RW-1:0]    res_a,
  input logic [RW-1:0]    res_b,
  input logic [HW-1:0]    sum_top
);

  localparam logic [RW-1:0] RES_MAX = RW'(1) << (WIDTH - 2);

  // R1
  product_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> product == PW'($past(opnd_x)) * PW'($past(opnd_y)));

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_ev |-> sum_top == '0);

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(product));

  // R4
  zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (opnd_x == '0 || opnd_y == '0) |=> product == '0);

  // R5
  resid_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_a <= RES_MAX && res_b <= RES_MAX);

  // R6
  exp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_a >= exp_b);

endmodule

bind bom_mult bom_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .opnd_x   (opnd_x),
  .opnd_y   (opnd_y),
  .out_valid(out_valid),
  .product  (product),
  .zero_ev  (zero_ev),
  .exp_a    (exp_a),
  .exp_b    (exp_b),
  .res_a    (res_a),
  .res_b    (res_b),
  .sum_top  (sum_top)
);

// File: tb/tb_bom_mult.sv
`timescale 1ns/1ps
module tb_bom_mult;
  localparam int W  = 16;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [W-1:0]  opnd_x, opnd_y;
  logic          out_valid;
  logic [PW-1:0] product;

  always #4 clk = ~clk;

  bom_mult #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .opnd_x(opnd_x), .opnd_y(opnd_y),
    .out_valid(out_valid), .product(product)
  );

  logic [PW-1:0] exp_q [$];
  string         tag_q [$];
  int vectors = 0;
  int miscmp  = 0;
  bit done    = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [PW-1:0] act, input logic [PW-1:0] expv);
    vectors++;
    if (!ok) begin
      miscmp++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // driver: presents a pair and pushes the reference product
  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    @(negedge clk);
    opnd_x   = a;
    opnd_y   = b;
    in_valid = 1'b1;
    exp_q.push_back(PW'(a) * PW'(b));
    tag_q.push_back(tag);
  endtask

  task automatic send_both(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    send(a, b, tag);
    send(b, a, {tag, " R6 swapped"});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: result one cycle after each accepted pair, in order (R2, R8)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected out_valid", product, '0);
      end else begin
        logic [PW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(product == e, t, product, e);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] held;
    rst_n = 1'b0; in_valid = 1'b0; opnd_x = '0; opnd_y = '0;
    repeat (3) @(negedge clk);
    // R2 reset state
    check(out_valid == 1'b0, "R2 reset out_valid", PW'(out_valid), '0);
    check(product == '0, "R2 reset product", product, '0);
    rst_n = 1'b1;
    idle(2);
    check(out_valid == 1'b0, "R2 idle out_valid", PW'(out_valid), '0);

    send(16'd10, 16'd9, "R1 10x9");
    send_both(16'd0, 16'hBEEF, "R4 zero operand");
    send(16'd0, 16'd0, "R4 both zero");
    send_both(16'd1, 16'hFFFF, "R5 one");
    send(16'd1, 16'd1, "R5 one by one");
    send(16'hFFFF, 16'hFFFF, "R7 all ones");
    send(16'h8000, 16'h8000, "R7 top power");
    idle(2);

    // R7 powers of two
    for (int i = 0; i < W; i += 3)
      for (int j = 0; j < W; j += 5)
        send(W'(1) << i, W'(1) << j, "R7 powers");

    // R5 midpoints and neighbours, in both orders
    for (int p = 1; p < W; p++) begin
      logic [W-1:0] mid;
      mid = W'((3 << p) >> 1);
      send_both(mid, 16'hFFFF, "R5 midpoint x ones");
      send_both(mid - 1, mid + 1, "R5 around midpoint");
      send_both(mid + 1, W'(1) << (p - 1), "R5 above mid x power");
      send(mid + 1, mid + 1, "R7 equal above mid");
    end

    // R7 equal operands
    send(16'h1234, 16'h1234, "R7 equal");
    send(16'h7FFF, 16'h7FFF, "R7 equal near top");

    // R3 hold with changing inputs
    send(16'h1234, 16'h0056, "R3 setup");
    held = PW'(16'h1234) * PW'(16'h0056);
    @(negedge clk);
    in_valid = 1'b0; opnd_x = '1; opnd_y = '1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      opnd_x = W'($urandom); opnd_y = W'($urandom);
      check(product == held, "R3 hold product", product, held);
      check(out_valid == 1'b0, "R2 no pulse when idle", PW'(out_valid), '0);
    end

    // R8 back-to-back random stream
    for (int i = 0; i < 400; i++)
      send(W'($urandom), W'($urandom), "R8 random stream");
    for (int i = 0; i < 100; i++)
      send_both(W'($urandom) >> ($urandom % W), W'($urandom), "R6 random order");
    idle(4);

    check(exp_q.size() == 0, "R8 all results returned", PW'(exp_q.size()), '0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

endmodule